// File: doc/BRIEF.md
# I2C Memory Slave Select Front End

This block listens to an I2C bus as a slave. Its SCL and SDA inputs are oversampled in one system clock domain. It finds START and STOP conditions and shifts in the byte that follows a START. It then decides whether the byte addresses this device. A device is addressed only when all seven select bits match: a fixed four-bit type code of binary 1010, followed by the three levels on the chip-enable straps. When they match, the block pulls SDA low during the ninth clock and reports the transfer direction.

For a write, the block keeps receiving data bytes. It acknowledges each one and presents it on a one-cycle byte-valid output. For a read, it only reports the direction and then stays off the bus, because sending read data is handled elsewhere. On a mismatch it stays silent until the next START or STOP.

The state machine has seven states:

- `ST_IDLE`: the bus is free.
- `ST_SEL`: the select byte is being shifted in.
- `ST_SEL_ACK`: the select byte is being acknowledged.
- `ST_RD_HOLD`: a read was selected; the block waits quietly.
- `ST_WR_DATA`: a write data byte is being shifted in.
- `ST_WR_ACK`: a data byte is being acknowledged.
- `ST_IGNORE`: the select byte did not match.

A START moves any state to `ST_SEL`, and a STOP moves any state to `ST_IDLE`; START wins if both are seen. All other moves happen on an SCL falling edge:

- `ST_SEL` goes to `ST_SEL_ACK` on a match, or to `ST_IGNORE` on a mismatch, once eight bits are in.
- `ST_SEL_ACK` goes to `ST_WR_DATA` for a write, or to `ST_RD_HOLD` for a read.
- `ST_WR_DATA` goes to `ST_WR_ACK` once eight bits are in.
- `ST_WR_ACK` goes back to `ST_WR_DATA`.

Top module: `i2c_sel_frontend`

## Requirements
- R1: While reset is asserted and right after it, `sda_oe_o`, `sel_valid_o`, `sel_rw_o`, `wr_valid_o` and `wr_data_o` are all 0.
- R2: A START is an SDA fall while SCL is high. No byte is acknowledged unless a START came before it; clocks sent after a STOP with no new START are never acknowledged.
- R3: The select byte is taken MSB first, with each bit sampled on an SCL rise. It matches when bits 7..4 equal 1010 and bits 3..1 equal `chip_en_i[2:0]`, with bit 3 compared to `chip_en_i[2]`. On a match, `sda_oe_o` rises on the SCL fall after the eighth bit and falls on the SCL fall after the ninth bit, which lies while SCL is low.
- R4: If any select bit differs, `sda_oe_o`, `sel_valid_o` and `wr_valid_o` stay 0 until the next START or STOP, including during any following data bytes.
- R5: After a matched select byte, `sel_valid_o` pulses for one clock on the SCL fall that ends the acknowledge. `sel_rw_o` then shows bit 0 of the select byte (1 = read, 0 = write) and holds it until the next report.
- R6: After a write select, each later byte is shifted MSB first. On the SCL fall after its eighth bit, `wr_valid_o` pulses for one clock with the byte on `wr_data_o`, and the byte is acknowledged with the same timing as in R3.
- R7: After a read select, the block drives no acknowledge and reports no data byte until the next START or STOP.
- R8: A STOP (SDA rise while SCL is high) ends the transfer. A later byte sent without a new START is not acknowledged.
- R9: A repeated START in the middle of a byte drops the partial byte and restarts select-byte capture from bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| chip_en_i | input | 3 | Strapped chip-enable bits, compared with select bits 3..1 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| sel_valid_o | output | 1 | One-clock pulse when a select byte has been acknowledged |
| sel_rw_o | output | 1 | Direction of the last accepted select (1 = read) |
| wr_valid_o | output | 1 | One-clock pulse when a write data byte is complete |
| wr_data_o | output | 8 | Last completed write data byte |

## Verification
The bench covers the following corner cases, and what a wrong design would do in each:

- **Single wrong bit.** The select code is sent with one chip-enable bit wrong, then with the type field wrong. A design that compares only part of the code would acknowledge these, and would also acknowledge the data byte that follows.
- **Clocks after STOP.** Bytes are clocked after a STOP with no new START. A design that keeps its state across a STOP would acknowledge them.
- **Repeated START mid-byte.** A START arrives in the middle of a byte. A design that does not clear its bit count would misalign the next select byte and stay silent.
- **Read select.** A design that treats reads like writes would acknowledge the byte that follows and report it as data.
- **Acknowledge window.** The exact clock when SDA is pulled and released is checked against a reference model, so a window that is shifted by one SCL edge shows up at once.

// File: rtl/i2c_sel_pkg.sv
package i2c_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_RD_HOLD,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_IGNORE
    } sel_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_sel_sync.sv
module i2c_sel_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_sel_events.sv
module i2c_sel_events
    import i2c_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        evt.start = scl_s && scl_q && sda_q && !sda_s;
        evt.stop  = scl_s && scl_q && !sda_q && sda_s;
        evt.rise  = scl_s && !scl_q;
        evt.fall  = !scl_s && scl_q;
        evt.sda   = sda_s;
    end
endmodule

// File: rtl/i2c_sel_fsm.sv
module i2c_sel_fsm
    import i2c_sel_pkg::*;
#(
    parameter int           TYPE_W    = 4,
    parameter logic [3:0]   TYPE_CODE = 4'b1010,
    parameter int           CE_W      = 3,
    parameter int           BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [CE_W-1:0]   chip_en,
    output logic              sda_oe,
    output logic              sel_valid,
    output logic              sel_rw,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam int SEL_W = TYPE_W + CE_W;

    sel_state_t        state, state_n;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              full_byte;
    logic              sel_match;
    logic              capturing;
    logic              restart_cnt;

    assign full_byte = (bit_cnt == CNT_W'(BYTE_W));
    assign sel_match = (shreg[BYTE_W-1 -: SEL_W] == {TYPE_CODE[TYPE_W-1:0], chip_en});
    assign capturing = (state == ST_SEL) || (state == ST_WR_DATA);
    assign restart_cnt = evt.start ||
                         ((state_n != state) && (state_n == ST_WR_DATA));

    // next-state logic
    always_comb begin
        state_n = state;
        if (evt.start) begin
            state_n = ST_SEL;
        end else if (evt.stop) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_SEL:     if (evt.fall && full_byte)
                                state_n = sel_match ? ST_SEL_ACK : ST_IGNORE;
                ST_SEL_ACK: if (evt.fall)
                                state_n = shreg[0] ? ST_RD_HOLD : ST_WR_DATA;
                ST_WR_DATA: if (evt.fall && full_byte)
                                state_n = ST_WR_ACK;
                ST_WR_ACK:  if (evt.fall)
                                state_n = ST_WR_DATA;
                default:    state_n = state;
            endcase
        end
    end

    // state register and shift path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            state <= state_n;
            if (restart_cnt) begin
                bit_cnt <= '0;
            end else if (capturing && evt.rise && !full_byte) begin
                shreg   <= {shreg[BYTE_W-2:0], evt.sda};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            sel_valid <= 1'b0;
            sel_rw    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_data   <= '0;
        end else begin
            sda_oe    <= (state_n == ST_SEL_ACK) || (state_n == ST_WR_ACK);
            sel_valid <= (state == ST_SEL_ACK) &&
                         ((state_n == ST_RD_HOLD) || (state_n == ST_WR_DATA));
            wr_valid  <= (state == ST_WR_DATA) && (state_n == ST_WR_ACK);
            if ((state == ST_SEL_ACK) && (state_n == ST_RD_HOLD || state_n == ST_WR_DATA))
                sel_rw <= shreg[0];
            if ((state == ST_WR_DATA) && (state_n == ST_WR_ACK))
                wr_data <= shreg;
        end
    end
endmodule

// File: rtl/i2c_sel_frontend.sv
module i2c_sel_frontend
    import i2c_sel_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE   = 4'b1010,
    parameter int         CE_W        = 3,
    parameter int         BYTE_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [CE_W-1:0]   chip_en_i,
    output logic              sda_oe_o,
    output logic              sel_valid_o,
    output logic              sel_rw_o,
    output logic              wr_valid_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam int TYPE_W = BYTE_W - 1 - CE_W;

    logic [1:0] pins_s;
    logic       scl_s;
    logic       sda_s;
    bus_evt_t   evt;

    i2c_sel_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (pins_s)
    );

    assign scl_s = pins_s[1];
    assign sda_s = pins_s[0];

    i2c_sel_events events_i (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_s(scl_s),
        .sda_s(sda_s),
        .evt  (evt)
    );

    i2c_sel_fsm #(
        .TYPE_W   (TYPE_W),
        .TYPE_CODE(TYPE_CODE),
        .CE_W     (CE_W),
        .BYTE_W   (BYTE_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .chip_en  (chip_en_i),
        .sda_oe   (sda_oe_o),
        .sel_valid(sel_valid_o),
        .sel_rw   (sel_rw_o),
        .wr_valid (wr_valid_o),
        .wr_data  (wr_data_o)
    );
endmodule

// File: rtl/i2c_sel_chk.sv
module i2c_sel_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic sel_valid,
    input logic sel_rw,
    input logic wr_valid
);
    // R3: the acknowledge drive starts only while the bus clock is low
    assert_oe_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3: the acknowledge drive is released only while the bus clock is low
    assert_oe_fall_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s);

    // R5: selection report is a single-cycle pulse
    assert_sel_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> !sel_valid);

    // R4: a selection is reported only after an acknowledge was driven
    assert_sel_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> $past(sda_oe));

    // R6: each completed write byte starts its acknowledge
    assert_wr_acked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> sda_oe);

    // R6: byte-valid is a single-cycle pulse
    assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R7: a read selection leaves the bus released
    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_rw) |-> !sda_oe);
endmodule

bind i2c_sel_frontend i2c_sel_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe_o),
    .sel_valid(sel_valid_o),
    .sel_rw   (sel_rw_o),
    .wr_valid (wr_valid_o)
);

// File: tb/i2c_sel_frontend_tb.sv
module i2c_sel_frontend_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    localparam int M_IDLE = 0, M_SEL = 1, M_SACK = 2, M_RHOLD = 3,
                   M_WDATA = 4, M_WACK = 5, M_IGN = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] chip_en = 3'b101;
    logic       sda_bus;
    logic       sda_oe_o, sel_valid_o, sel_rw_o, wr_valid_o;
    logic [7:0] wr_data_o;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe_o;

    i2c_sel_frontend dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .chip_en_i  (chip_en),
        .sda_oe_o   (sda_oe_o),
        .sel_valid_o(sel_valid_o),
        .sel_rw_o   (sel_rw_o),
        .wr_valid_o (wr_valid_o),
        .wr_data_o  (wr_data_o)
    );

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [1:0] hist[$];
    int   m_mode, m_cnt;
    logic [7:0] m_sh;
    logic e_oe, e_sel_v, e_rw, e_wr_v;
    logic [7:0] e_wr_d;
    bit   model_on = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{2'b11, 2'b11, 2'b11, 2'b11};
            m_mode = M_IDLE; m_cnt = 0; m_sh = 0;
            e_oe = 0; e_sel_v = 0; e_rw = 0; e_wr_v = 0; e_wr_d = 0;
        end else begin
            logic c_scl, c_sda, p_scl, p_sda;
            hist.push_back({m_scl, sda_bus});
            void'(hist.pop_front());
            {c_scl, c_sda} = hist[1];
            {p_scl, p_sda} = hist[0];
            e_sel_v = 0; e_wr_v = 0;
            if (c_scl && p_scl && p_sda && !c_sda) begin
                m_mode = M_SEL; m_cnt = 0;
            end else if (c_scl && p_scl && !p_sda && c_sda) begin
                m_mode = M_IDLE;
            end else begin
                if ((m_mode == M_SEL || m_mode == M_WDATA) && c_scl && !p_scl && m_cnt < 8) begin
                    m_sh = {m_sh[6:0], c_sda};
                    m_cnt++;
                end else if (!c_scl && p_scl) begin
                    case (m_mode)
                        M_SEL: if (m_cnt == 8)
                            m_mode = (m_sh[7:1] == {4'b1010, chip_en}) ? M_SACK : M_IGN;
                        M_SACK: begin
                            e_sel_v = 1; e_rw = m_sh[0];
                            m_mode = m_sh[0] ? M_RHOLD : M_WDATA;
                            m_cnt = 0;
                        end
                        M_WDATA: if (m_cnt == 8) begin
                            e_wr_v = 1; e_wr_d = m_sh; m_mode = M_WACK;
                        end
                        M_WACK: begin m_mode = M_WDATA; m_cnt = 0; end
                        default: ;
                    endcase
                end
            end
            e_oe = (m_mode == M_SACK) || (m_mode == M_WACK);
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check("R3 sda_oe", sda_oe_o, e_oe);
            check("R5 sel_valid", sel_valid_o, e_sel_v);
            check("R5 sel_rw", sel_rw_o, e_rw);
            check("R6 wr_valid", wr_valid_o, e_wr_v);
            check("R6 wr_data", wr_data_o, e_wr_d);
        end
    end

    // ---------------- scenario monitors ----------------
    int ack_cnt, sel_cnt, wr_cnt;
    logic last_rw, prev_oe;
    logic [7:0] wr_q[$];

    always @(negedge clk) begin
        if (sda_oe_o && !prev_oe) ack_cnt++;
        prev_oe = sda_oe_o;
        if (sel_valid_o) begin sel_cnt++; last_rw = sel_rw_o; end
        if (wr_valid_o) begin wr_cnt++; wr_q.push_back(wr_data_o); end
    end

    task automatic clr();
        ack_cnt = 0; sel_cnt = 0; wr_cnt = 0; wr_q.delete();
    endtask

    // ---------------- bus master ----------------
    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        m_sda = b; hold(4);
        m_scl = 1'b1; hold(8);
        m_scl = 1'b0; hold(6);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(1'b1);
    endtask

    task automatic do_start();
        m_scl = 1'b1; m_sda = 1'b1; hold(8);
        m_sda = 1'b0; hold(8);
        m_scl = 1'b0; hold(6);
    endtask

    task automatic do_rstart();
        m_sda = 1'b1; hold(4);
        m_scl = 1'b1; hold(8);
        m_sda = 1'b0; hold(8);
        m_scl = 1'b0; hold(6);
    endtask

    task automatic do_stop();
        m_sda = 1'b0; hold(4);
        m_scl = 1'b1; hold(8);
        m_sda = 1'b1; hold(8);
    endtask

    task automatic scl_low();
        m_sda = 1'b1; m_scl = 1'b0; hold(6);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ack_cnt = 0; sel_cnt = 0; wr_cnt = 0; prev_oe = 0; last_rw = 0;
        hold(5);
        // R1 reset state
        check("R1 sda_oe", sda_oe_o, 0);
        check("R1 sel_valid", sel_valid_o, 0);
        check("R1 wr_valid", wr_valid_o, 0);
        check("R1 wr_data", wr_data_o, 0);
        rst_n = 1'b1;
        model_on = 1;
        hold(4);
        check("R1 sel_rw", sel_rw_o, 0);

        // A: matching write, two data bytes
        clr(); do_start(); send_byte(8'hAA); send_byte(8'hA5); send_byte(8'h3C); do_stop();
        check("R3 acks", ack_cnt, 3);
        check("R5 sel count", sel_cnt, 1);
        check("R5 rw write", last_rw, 0);
        check("R6 byte count", wr_cnt, 2);
        if (wr_q.size() == 2) begin
            check("R6 byte0", wr_q[0], 8'hA5);
            check("R6 byte1", wr_q[1], 8'h3C);
        end

        // B: matching read, following byte must not be acknowledged
        clr(); do_start(); send_byte(8'hAB); send_byte(8'hFF); do_stop();
        check("R7 acks", ack_cnt, 1);
        check("R5 rw read", last_rw, 1);
        check("R7 no data", wr_cnt, 0);

        // C: chip-enable mismatch
        clr(); do_start(); send_byte(8'hA8); send_byte(8'h55); do_stop();
        check("R4 ce acks", ack_cnt, 0);
        check("R4 ce sel", sel_cnt, 0);
        check("R4 ce data", wr_cnt, 0);

        // D: type field mismatch
        clr(); do_start(); send_byte(8'hEA); send_byte(8'h55); do_stop();
        check("R4 type acks", ack_cnt, 0);

        // E: no START before select byte
        clr(); scl_low(); send_byte(8'hAA); send_byte(8'h11); do_stop();
        check("R2 no start acks", ack_cnt, 0);
        check("R2 no start data", wr_cnt, 0);

        // F: repeated START in mid-byte
        clr(); do_start();
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        do_rstart(); send_byte(8'hAA); send_byte(8'h77); do_stop();
        check("R9 acks", ack_cnt, 2);
        check("R9 data count", wr_cnt, 1);
        if (wr_q.size() == 1) check("R9 data", wr_q[0], 8'h77);

        // G: STOP ends the transfer
        clr(); do_start(); send_byte(8'hAA); send_byte(8'h12); do_stop();
        scl_low(); send_byte(8'h34); do_stop();
        check("R8 acks", ack_cnt, 2);
        check("R8 data count", wr_cnt, 1);

        // H: different strap pattern
        chip_en = 3'b010; hold(4);
        clr(); do_start(); send_byte(8'hA4); send_byte(8'h9A); do_stop();
        check("R3 strap acks", ack_cnt, 2);
        if (wr_q.size() == 1) check("R3 strap data", wr_q[0], 8'h9A);
        else check("R3 strap data count", wr_q.size(), 1);
        clr(); do_start(); send_byte(8'hAA); do_stop();
        check("R3 old strap rejected", ack_cnt, 0);

        hold(10);
        finish_run();
    end
endmodule